// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the processor-facing register file of a 16550-style UART that has been extended with additional register banks. The host reaches it through an 8-bit data bus with 3-bit offsets and separate read and write strobes. The value last written to the line control register picks which bank the other offsets decode to. The line control register stays visible at offset 3 in every bank, so software can always move between banks.

Bank 0 holds the ordinary modem control register. The divisor bank and the extended bank both expose the two divisor latch bytes. The extended bank also exposes two extra registers. The first is a read-only image of the modem loopback bit. The second carries a lock flag and a 2-bit prescaler select.

The divisor, the prescaler select and the modem control bits leave the block as registered outputs for a baud-rate generator and for the line logic. Moving into the divisor bank from any other bank returns the prescaler/lock register to zero. This lets legacy software that only knows the divisor bank always get the default prescaler.

Top module: `uart_bank_regs`

## Requirements
- R1: After a synchronous reset, every register is zero, bank 0 is selected, and `rdata_o`, `divisor_o`, `presl_o` and `mcr_o` read zero.
- R2: The bank is chosen by the line control value. Bit 7 clear selects bank 0. Bits 7:5 equal to 3'b111 select bank 2 (for example 0xE0). Any other value with bit 7 set selects bank 1. The line control register reads and writes at offset 3 in all three banks.
- R3: In bank 0, offset 4 is the modem control register. It stores bits 4:0, reads bits 7:5 as zero, and drives `mcr_o`. Bit 4 is the loopback bit.
- R4: In banks 1 and 2, offset 0 is the low divisor byte and offset 1 is the high divisor byte. Both banks use the same storage, and `divisor_o` = {high, low}.
- R5: Writes to offsets 0 and 1 in bank 0 leave the divisor unchanged.
- R6: In bank 2, offset 2 reads the modem loopback bit at bit 4 and zero in every other bit. Writes to this offset have no effect.
- R7: In bank 2, offset 4 is the extended control register. Bit 7 is LOCK and bits 5:4 are the prescaler select, which drives `presl_o`. All other bits read zero.
- R8: While LOCK is set, a write to offset 4 in bank 2 leaves the prescaler select unchanged, but the write still updates LOCK itself.
- R9: A line control write that moves the decoded bank from bank 0 or bank 2 into bank 1 clears LOCK and the prescaler select. A move between bank 0 and bank 2 preserves them.
- R10: `rdata_o` loads on the clock edge where `rd_en` is high and holds its value otherwise. A read and a write to the same offset in the same cycle return the value from before the write.
- R11: Offsets with no register in the current bank read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Registered read data |
| divisor_o | output | 16 | Baud divisor to the rate generator |
| presl_o | output | 2 | Prescaler select to the rate generator |
| mcr_o | output | 5 | Modem control bits |

## Verification
Two functions can fall in the same cycle. The first is a read that captures a register. The second is a write that changes that same register. The bench raises both strobes together on the modem control offset and expects the returned byte to be the old contents; a following plain read must then show the new contents. A second case is a line control write that changes the bank while the read mux is decoding with the old bank. The bench judges it by reading through the new bank on the next access, and by checking that a move from bank 2 to bank 1 clears the prescaler register while a detour through bank 0 leaves it intact.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  typedef enum logic [1:0] {
    BANK_STD = 2'd0,
    BANK_DIV = 2'd1,
    BANK_EXT = 2'd2
  } bank_e;

  // register offsets (host visible)
  localparam int OFS_DIV_LO   = 0;
  localparam int OFS_DIV_HI   = 1;
  localparam int OFS_MIRROR   = 2;
  localparam int OFS_LINE     = 3;
  localparam int OFS_CTL      = 4;

  // bit positions
  localparam int LOOP_BIT     = 4;
  localparam int LOCK_BIT     = 7;
  localparam int PRESL_LSB    = 4;

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
(
  input  logic [2:0] line_top,   // line control bits 7:5
  output bank_e      bank
);

  always_comb begin
    if (!line_top[2])        bank = BANK_STD;
    else if (&line_top)      bank = BANK_EXT;
    else                     bank = BANK_DIV;
  end

endmodule

// File: rtl/uart_bank_divisor.sv
module uart_bank_divisor #(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int SEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int DIV_W    = DATA_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  byte_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  divisor
);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        divisor[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && byte_sel == SEL_W'(g))
        divisor[g*DATA_W +: DATA_W] <= wdata;
    end
  end

endmodule

// File: rtl/uart_bank_ext.sv
module uart_bank_ext #(
  parameter int DATA_W    = 8,
  parameter int PRESL_W   = 2,
  parameter int PRESL_LSB = 4,
  parameter int LOCK_BIT  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               clear,
  input  logic [DATA_W-1:0]  wdata,
  output logic               lock_q,
  output logic [PRESL_W-1:0] presl_q,
  output logic [DATA_W-1:0]  rd_val
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lock_q  <= 1'b0;
      presl_q <= '0;
    end else if (wr) begin
      lock_q <= wdata[LOCK_BIT];
      if (!lock_q)
        presl_q <= wdata[PRESL_LSB +: PRESL_W];
    end
  end

  always_comb begin
    rd_val = '0;
    rd_val[LOCK_BIT] = lock_q;
    rd_val[PRESL_LSB +: PRESL_W] = presl_q;
  end

  // R8: a locked register keeps its prescaler across writes
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && !clear && lock_q) |=> $stable(presl_q));

  // R9: entering the divisor bank zeroes the register
  p_enter_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (presl_q == '0 && !lock_q));

  // R7: an unlocked write lands in the prescaler field
  p_unlocked_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && !clear && !lock_q) |=> presl_q == $past(wdata[PRESL_LSB +: PRESL_W]));

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  parameter int MODEM_BITS = 5,
  parameter int PRESL_W    = 2,
  localparam int DIV_BYTES = 2,
  localparam int DIV_W     = DATA_W * DIV_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [DIV_W-1:0]      divisor_o,
  output logic [PRESL_W-1:0]    presl_o,
  output logic [MODEM_BITS-1:0] mcr_o
);

  logic [DATA_W-1:0]     lcr_q;
  logic [MODEM_BITS-1:0] mcr_q;
  bank_e                 bank, next_bank;
  logic                  at_div_lo, at_div_hi, at_mirror, at_line, at_ctl;
  logic                  wr_line, wr_modem, wr_div, wr_ctl, enter_div;
  logic                  ext_lock;
  logic [DATA_W-1:0]     ext_rd, rd_mux;

  assign at_div_lo = (addr == ADDR_W'(OFS_DIV_LO));
  assign at_div_hi = (addr == ADDR_W'(OFS_DIV_HI));
  assign at_mirror = (addr == ADDR_W'(OFS_MIRROR));
  assign at_line   = (addr == ADDR_W'(OFS_LINE));
  assign at_ctl    = (addr == ADDR_W'(OFS_CTL));

  uart_bank_decode u_cur_dec (
    .line_top (lcr_q[DATA_W-1 -: 3]),
    .bank     (bank)
  );

  uart_bank_decode u_nxt_dec (
    .line_top (wdata[DATA_W-1 -: 3]),
    .bank     (next_bank)
  );

  assign wr_line   = wr_en && at_line;
  assign wr_modem  = wr_en && at_ctl && (bank == BANK_STD);
  assign wr_ctl    = wr_en && at_ctl && (bank == BANK_EXT);
  assign wr_div    = wr_en && (at_div_lo || at_div_hi) && (bank != BANK_STD);
  assign enter_div = wr_line && (next_bank == BANK_DIV) && (bank != BANK_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q <= '0;
      mcr_q <= '0;
    end else begin
      if (wr_line)  lcr_q <= wdata;
      if (wr_modem) mcr_q <= wdata[MODEM_BITS-1:0];
    end
  end

  uart_bank_divisor #(
    .DATA_W    (DATA_W),
    .NUM_BYTES (DIV_BYTES)
  ) u_divisor (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_div),
    .byte_sel (at_div_hi),
    .wdata    (wdata),
    .divisor  (divisor_o)
  );

  uart_bank_ext #(
    .DATA_W    (DATA_W),
    .PRESL_W   (PRESL_W),
    .PRESL_LSB (PRESL_LSB),
    .LOCK_BIT  (LOCK_BIT)
  ) u_ext (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_ctl),
    .clear   (enter_div),
    .wdata   (wdata),
    .lock_q  (ext_lock),
    .presl_q (presl_o),
    .rd_val  (ext_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (at_line) begin
      rd_mux = lcr_q;
    end else begin
      unique case (bank)
        BANK_STD: if (at_ctl) rd_mux = DATA_W'(mcr_q);
        BANK_DIV: begin
          if (at_div_lo)      rd_mux = divisor_o[DATA_W-1:0];
          else if (at_div_hi) rd_mux = divisor_o[DIV_W-1:DATA_W];
        end
        BANK_EXT: begin
          if (at_div_lo)      rd_mux = divisor_o[DATA_W-1:0];
          else if (at_div_hi) rd_mux = divisor_o[DIV_W-1:DATA_W];
          else if (at_mirror) rd_mux[LOOP_BIT] = mcr_q[LOOP_BIT];
          else if (at_ctl)    rd_mux = ext_rd;
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  assign mcr_o = mcr_q;

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_o));

  // R2: line control readable in any bank
  p_line_any_bank_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && at_line) |=> rdata_o == $past(lcr_q));

  // R5: bank 0 writes never reach the divisor
  p_div_guard_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank == BANK_STD) |=> $stable(divisor_o));

  // R6: mirror read carries only the loopback bit
  p_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && at_mirror && bank == BANK_EXT) |=>
      (rdata_o[LOOP_BIT] == $past(mcr_q[LOOP_BIT]) && $countones(rdata_o) <= 1));

  // R8: lock output consistent with extended read value
  p_lock_view_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && at_ctl && bank == BANK_EXT) |=> rdata_o[LOCK_BIT] == $past(ext_lock));

endmodule

// File: tb/uart_bank_regs_bench.sv
module uart_bank_regs_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata_o;
  logic [15:0] divisor_o;
  logic [1:0] presl_o;
  logic [4:0] mcr_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_bank_regs u_uart_bank_regs (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata_o(rdata_o),
    .divisor_o(divisor_o), .presl_o(presl_o), .mcr_o(mcr_o)
  );

  // {req, write, offset, data, expected}
  localparam int NV = 45;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0,3'd3,8'h00,8'h00},  // R1 line ctl zero
    {4'd3, 1'b1,3'd4,8'h13,8'h00},
    {4'd3, 1'b0,3'd4,8'h00,8'h13},  // R3
    {4'd3, 1'b1,3'd4,8'hF5,8'h00},
    {4'd3, 1'b0,3'd4,8'h00,8'h15},  // R3 upper bits dropped
    {4'd11,1'b0,3'd5,8'h00,8'h00},  // R11
    {4'd5, 1'b1,3'd0,8'hAA,8'h00},  // R5 bank 0 write
    {4'd2, 1'b1,3'd3,8'h83,8'h00},
    {4'd2, 1'b0,3'd3,8'h00,8'h83},  // R2
    {4'd5, 1'b0,3'd0,8'h00,8'h00},  // R5 divisor untouched
    {4'd4, 1'b1,3'd0,8'h34,8'h00},
    {4'd4, 1'b1,3'd1,8'h12,8'h00},
    {4'd4, 1'b0,3'd0,8'h00,8'h34},  // R4
    {4'd4, 1'b0,3'd1,8'h00,8'h12},  // R4
    {4'd11,1'b0,3'd2,8'h00,8'h00},  // R11 bank 1 offset 2
    {4'd2, 1'b1,3'd3,8'hE0,8'h00},
    {4'd2, 1'b0,3'd3,8'h00,8'hE0},  // R2
    {4'd4, 1'b0,3'd1,8'h00,8'h12},  // R4 shared storage
    {4'd6, 1'b0,3'd2,8'h00,8'h10},  // R6 mirror
    {4'd6, 1'b1,3'd2,8'hFF,8'h00},
    {4'd6, 1'b0,3'd2,8'h00,8'h10},  // R6 write ignored
    {4'd7, 1'b1,3'd4,8'h3F,8'h00},
    {4'd7, 1'b0,3'd4,8'h00,8'h30},  // R7
    {4'd8, 1'b1,3'd4,8'hA0,8'h00},
    {4'd8, 1'b0,3'd4,8'h00,8'hA0},  // R8 lock set
    {4'd8, 1'b1,3'd4,8'h90,8'h00},
    {4'd8, 1'b0,3'd4,8'h00,8'hA0},  // R8 presl held
    {4'd8, 1'b1,3'd4,8'h10,8'h00},
    {4'd8, 1'b0,3'd4,8'h00,8'h20},  // R8 unlock, presl held
    {4'd7, 1'b1,3'd4,8'hB0,8'h00},
    {4'd7, 1'b0,3'd4,8'h00,8'hB0},  // R7
    {4'd2, 1'b1,3'd3,8'h03,8'h00},
    {4'd2, 1'b0,3'd4,8'h00,8'h15},  // R2 back in bank 0
    {4'd6, 1'b1,3'd4,8'h05,8'h00},
    {4'd2, 1'b1,3'd3,8'hE0,8'h00},
    {4'd6, 1'b0,3'd2,8'h00,8'h00},  // R6 loop cleared
    {4'd9, 1'b0,3'd4,8'h00,8'hB0},  // R9 kept across bank 0
    {4'd9, 1'b1,3'd3,8'h80,8'h00},
    {4'd9, 1'b1,3'd3,8'hE0,8'h00},
    {4'd9, 1'b0,3'd4,8'h00,8'h00},  // R9 cleared
    {4'd4, 1'b0,3'd0,8'h00,8'h34},  // R4 intact
    {4'd2, 1'b1,3'd3,8'hC0,8'h00},
    {4'd2, 1'b0,3'd0,8'h00,8'h34},  // R2 0xC0 is bank 1
    {4'd2, 1'b1,3'd3,8'h60,8'h00},
    {4'd2, 1'b0,3'd4,8'h00,8'h05}   // R2 0x60 is bank 0
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, "rdata reset", rdata_o, 0);
    check(1, "divisor reset", divisor_o, 0);
    check(1, "presl reset", presl_o, 0);
    check(1, "mcr reset", mcr_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      bus(v[19], !v[19], v[18:16], v[15:8]);
      if (!v[19]) check(int'(v[23:20]), $sformatf("vector %0d", i), rdata_o, v[7:0]);
    end

    check(4, "divisor out", divisor_o, 16'h1234);   // R4
    check(9, "presl after clear", presl_o, 0);      // R9
    check(3, "mcr out", mcr_o, 5'h05);              // R3

    bus(1'b1, 1'b0, 3'd3, 8'hE0);
    bus(1'b1, 1'b0, 3'd4, 8'h20);
    check(7, "presl out", presl_o, 2);              // R7

    // R10 same-cycle read and write
    bus(1'b1, 1'b0, 3'd3, 8'h00);
    bus(1'b1, 1'b1, 3'd4, 8'h0A);
    check(10, "read during write", rdata_o, 8'h05);
    bus(1'b0, 1'b1, 3'd4, 8'h00);
    check(10, "read after write", rdata_o, 8'h0A);
    // R10 hold without strobe
    @(negedge clk); addr = 3'd3;
    repeat (3) @(negedge clk);
    check(10, "rdata hold", rdata_o, 8'h0A);

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1, "rdata after reset", rdata_o, 0);
    check(1, "divisor after reset", divisor_o, 0);
    check(1, "presl after reset", presl_o, 0);
    check(1, "mcr after reset", mcr_o, 0);
    bus(1'b0, 1'b1, 3'd3, 8'h00);
    check(1, "line ctl after reset", rdata_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule